// File: doc/BRIEF.md
# Fixed-Point PI Voltage Controller

This block runs one step of a discrete-time proportional-integral regulator on 16-bit signed Q15 samples. A measured voltage sample and a reference arrive together with two gains. A one-cycle start pulse begins the computation.

The block forms the error, measured minus reference. It builds a proportional term from that error and adds a pre-scaled integral increment to an internal state. It then outputs the saturated sum of the two terms. One multiplier is shared by both terms and is used in consecutive clock cycles. A one-cycle done pulse marks each new output. The output holds its value until the next step completes.

Gain scaling is done with shifts. The proportional product is multiplied by 16 after it is saturated. The error is divided by 4 before the integral multiply. With these shifts, a Q15 coefficient can represent a proportional gain above one and a very small integral gain. Every intermediate result is clamped rather than allowed to wrap.

Top module: `pi_step_ctrl`

## Requirements
- R1: Values are two's-complement Q15: 0x7FFF is the largest value and 0x8000 the smallest. The error is meas minus ref_v, clamped to [0x8000, 0x7FFF] instead of wrapping.
- R2: The proportional term is the product kp·error shifted right by 15 with floor rounding, clamped to Q15. It is then shifted left by 4 and clamped to Q15 again. For example, 0x8000·0x8000 gives 0x7FFF.
- R3: The integral increment is ki times (error arithmetically shifted right by 2), shifted right by 15 with floor rounding. It is added to the stored integral state, the sum is clamped to Q15, and the result becomes the new state.
- R4: The output y is the clamped sum of the new proportional term and the new integral state.
- R5: done is a one-cycle pulse. It is high at the fourth rising edge after the edge that sampled start high while idle, and y takes its new value at that same edge.
- R6: A start pulse that arrives while a step is in progress has no effect. It produces no extra done pulse and no extra integral update.
- R7: y changes only at an edge where done goes high.
- R8: A synchronous active-high reset clears the integral state, y and done to zero and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one control step (sampled when idle) |
| meas | input | 16 | Measured voltage, Q15 |
| ref_v | input | 16 | Voltage reference, Q15 |
| kp | input | 16 | Proportional coefficient, Q15 (effective gain ×16) |
| ki | input | 16 | Integral coefficient, Q15 (applied to error/4) |
| done | output | 1 | One-cycle pulse: y is new |
| y | output | 16 | Controller output, Q15 |

## Verification
The assertions check on every cycle the following properties:
- done lasts exactly one cycle and follows an accepted start by four edges.
- y never moves without done.
- The integral state is frozen while idle.
- The proportional phase is never entered from a busy state.

The arithmetic itself can only be shown by the bench's scenarios, which compare results against an independent model. These scenarios include:
- error clamping at opposite full-scale inputs
- the fractional −1·−1 product
- clamping of the 16× shift
- integral wind-up into the positive rail and recovery from it
- the state cleared by reset

// File: rtl/pi_step_ctrl.sv
module pi_step_ctrl #(
  parameter int W     = 16,
  parameter int P_SHL = 4,
  parameter int I_SHR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] meas,
  input  logic signed [W-1:0] ref_v,
  input  logic signed [W-1:0] kp,
  input  logic signed [W-1:0] ki,
  output logic                done,
  output logic signed [W-1:0] y
);
  localparam int XW = 2*W + 2;
  localparam logic signed [XW-1:0] HI = XW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [XW-1:0] LO = -XW'(64'sd1 <<< (W-1));

  typedef enum logic [1:0] {S_IDLE, S_PROP, S_INTEG, S_SUM} state_t;
  state_t state;

  logic signed [W-1:0]   err_r, kp_r, ki_r, p_r, integ_r;
  logic signed [W-1:0]   mul_a, mul_b;
  logic signed [2*W-1:0] prod;
  logic signed [XW-1:0]  frac;

  function automatic logic signed [W-1:0] clamp(input logic signed [XW-1:0] v);
    if (v > HI)      return HI[W-1:0];
    else if (v < LO) return LO[W-1:0];
    else             return v[W-1:0];
  endfunction

  assign mul_a = (state == S_PROP) ? err_r : (err_r >>> I_SHR);
  assign mul_b = (state == S_PROP) ? kp_r  : ki_r;
  assign prod  = mul_a * mul_b;
  assign frac  = XW'(prod) >>> (W-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      err_r   <= '0;
      kp_r    <= '0;
      ki_r    <= '0;
      p_r     <= '0;
      integ_r <= '0;
      y       <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err_r <= clamp(XW'(meas) - XW'(ref_v));
          kp_r  <= kp;
          ki_r  <= ki;
          state <= S_PROP;
        end
        S_PROP: begin
          p_r   <= clamp(XW'(clamp(frac)) <<< P_SHL);
          state <= S_INTEG;
        end
        S_INTEG: begin
          integ_r <= clamp(XW'(integ_r) + frac);
          state   <= S_SUM;
        end
        default: begin
          y     <= clamp(XW'(p_r) + XW'(integ_r));
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 4));
  a_r7_y_holds: assert property (@(posedge clk) disable iff (rst)
    !$stable(y) |-> done);
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> (state != S_PROP));
  a_r3_state_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |=> $stable(integ_r));
endmodule

// File: tb/pi_step_ctrl_tb.sv
module pi_step_ctrl_tb;
  logic clk = 1'b0;
  logic rst, start;
  logic signed [15:0] meas, ref_v, kp, ki, y;
  logic done;
  int errors = 0, checks = 0, cyc = 0;
  longint mi = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pi_step_ctrl u_dut (.clk(clk), .rst(rst), .start(start), .meas(meas), .ref_v(ref_v),
                      .kp(kp), .ki(ki), .done(done), .y(y));

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint model(longint a, longint b, longint g1, longint g2);
    longint e, p;
    e  = sat(a - b);
    p  = sat(sat((g1 * e) >>> 15) * 16);
    mi = sat(mi + ((g2 * (e >>> 2)) >>> 15));
    return sat(p + mi);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic signed [15:0] a, b, g1, g2, output int lat);
    meas = a; ref_v = b; kp = g1; ki = g2; start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic do_reset();
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0; mi = 0;
  endtask

  typedef struct packed { logic [15:0] a, b, g1, g2; } vec_t;
  localparam vec_t VEC [8] = '{
    '{16'h0100, 16'h0000, 16'h4000, 16'h2000},
    '{16'h0000, 16'h0400, 16'h1000, 16'h7FFF},
    '{16'hC000, 16'h3000, 16'h0800, 16'h4000},
    '{16'h1234, 16'h1234, 16'h6000, 16'h0200},
    '{16'h7000, 16'h9000, 16'h0100, 16'h8000},
    '{16'h0010, 16'h0020, 16'h7FFF, 16'h7FFF},
    '{16'hF000, 16'h0F00, 16'h8000, 16'h0040},
    '{16'h2000, 16'h0000, 16'h0600, 16'h0200}};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat, n;
    start = 0; meas = 0; ref_v = 0; kp = 0; ki = 0;
    do_reset();
    chk("R8 reset y", y, 0);
    chk("R8 reset done", done, 0);

    // R2 saturation of the x16 shift, R5 latency
    step(16'sh2000, 16'sh0000, 16'sh6000, 16'sh0040, lat);
    chk("R5 latency", lat, 4);
    chk("R2 shift clamp", y, 32767);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    chk("R7 y holds", y, 32767);

    do_reset();
    step(16'sh1000, 16'sh1800, 16'sh0800, 16'sh4000, lat);
    chk("R3 R4 negative step", y, -2304);

    do_reset();
    step(16'sh7FFF, -16'sh8000, 16'sh0800, 16'sh0000, lat);
    chk("R1 error clamp", y, 32752);

    do_reset();
    step(-16'sh8000, 16'sh0000, -16'sh8000, 16'sh0000, lat);
    chk("R2 minus one squared", y, 32767);

    // R3 integral wind-up and recovery
    do_reset();
    for (int k = 0; k < 5; k++) step(16'sh7FFF, 16'sh0000, 16'sh0000, 16'sh7FFF, lat);
    chk("R3 integral clamp", y, 32767);
    step(-16'sh8000, 16'sh0000, 16'sh0000, 16'sh7FFF, lat);
    chk("R3 recover from clamp", y, 24575);

    // R8 reset clears integral state
    do_reset();
    step(16'sh0000, 16'sh0000, 16'sh0000, 16'sh0000, lat);
    chk("R8 state cleared", y, 0);

    // Vector table against the model
    do_reset();
    for (int k = 0; k < 8; k++) begin
      step(VEC[k].a, VEC[k].b, VEC[k].g1, VEC[k].g2, lat);
      chk("R4 vector", y, model(longint'($signed(VEC[k].a)), longint'($signed(VEC[k].b)),
                                longint'($signed(VEC[k].g1)), longint'($signed(VEC[k].g2))));
    end

    // R6 start while busy is ignored
    do_reset();
    meas = 16'sh0400; ref_v = 0; kp = 0; ki = 16'sh4000; start = 1'b1;
    @(negedge clk); @(negedge clk); start = 1'b0;
    n = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (done) n++; end
    chk("R6 single done", n, 1);
    chk("R6 single update", y, 128);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule